// File: doc/BRIEF.md
# TLB Miss Assist-Register Preloader

When a translation lookup misses, system software has to build a replacement entry before it can retry the access. This block prepares that work in hardware. On a one-cycle miss strobe it loads six assist registers in a single clock edge:

- the entry-placement register;
- the tag register;
- the page-number register;
- the permission register;
- the search register;
- the high-address register.

The values come from three sources: a software-programmed template register, the faulting effective address, and the current address-space and process-ID state. Software then only edits the fields it cares about and commits the entry.

An external process-ID override replaces the normal ID sources. The override is used for loads and stores made on behalf of another context. A round-robin victim pointer picks the way that the new entry should replace and also reports the way that follows it. A small registered helper turns a page-size code into a byte count.

The block writes no translation array and raises no exception. It only produces register values.

Top module: `tlb_miss_prefill`

## Requirements
- R1: While `rst` is high at a clock edge, every register output and `page_bytes_o` become zero, and the victim pointer returns to way 0.
- R2: On a miss, the template's array-select bits `tmpl_i[1:0]` go to `sel_o[29:28]`. Its size code `tmpl_i[11:8]` goes to `tag_o[11:8]`, and its cache-attribute bits `tmpl_i[20:16]` go to `epn_o[4:0]`. `perm_o` and `hi_o` become zero.
- R3: On a miss, the valid bit `tag_o[31]` is set. `epn_o[31:12]` takes `addr_i[31:12]`, and `epn_o[11:5]` is zero.
- R4: The effective address space is chosen as follows: `inst_space_i` for an instruction fetch (`fetch_i`=1); otherwise `ext_space_i` when `ext_en_i` is set; otherwise `data_space_i`. It is written to `tag_o[30]` and `srch_o[0]`.
- R5: Without override, the tag ID `tag_o[29:16]` is chosen by the selector `tmpl_i[25:24]`: 0 gives `pid0_i`, 1 gives `pid1_i`, 2 gives `pid2_i` and 3 gives zero. The search ID `srch_o[29:16]` is always `pid0_i`.
- R6: With `ext_en_i` set, both `tag_o[29:16]` and `srch_o[29:16]` take `ext_pid_i`, and the selector has no effect.
- R7: On a miss, `sel_o[17:16]` receives the current victim way and `sel_o[1:0]` receives (way+1) mod `WAYS`. The pointer then advances by one modulo `WAYS` and wraps from 3 to 0.
- R8: Without a miss strobe, all six register outputs hold their values and the victim pointer does not advance, whatever the other inputs do.
- R9: `page_bytes_o` equals 1024 shifted left by `size_code_i`, one clock after the code is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_i | input | 1 | One-cycle miss strobe |
| fetch_i | input | 1 | Miss came from an instruction fetch |
| addr_i | input | ADDR_W | Faulting effective address |
| inst_space_i | input | 1 | Instruction address-space bit |
| data_space_i | input | 1 | Data address-space bit |
| ext_en_i | input | 1 | External process-ID override active |
| ext_pid_i | input | PID_W | External process ID |
| ext_space_i | input | 1 | Address space carried by the override |
| pid0_i | input | PID_W | Primary process ID |
| pid1_i | input | PID_W | Secondary process ID |
| pid2_i | input | PID_W | Tertiary process ID |
| tmpl_i | input | 32 | Default-value template register |
| size_code_i | input | 4 | Page-size code to decode |
| sel_o | output | 32 | Entry-placement register |
| tag_o | output | 32 | Tag register (valid, space, ID, size) |
| epn_o | output | ADDR_W | Page-number and attribute register |
| perm_o | output | 32 | Permission register |
| srch_o | output | 32 | Search register (ID, space) |
| hi_o | output | 32 | High-address register |
| page_bytes_o | output | 26 | Decoded page size in bytes |

## Verification
The assertions assume that every input is a known value at the sampling edge and that `WAYS` is a power of two. The pointer-chaining check also assumes the miss strobe is the only thing that moves the victim pointer after reset. The bench drives all inputs on the falling clock edge and keeps each miss strobe one cycle wide. It samples outputs on the next falling edge, so no input changes near the capturing edge. Process IDs stay within `PID_W` bits, and the size code stays within its four bits.

// File: rtl/missfill_pkg.sv
package missfill_pkg;
  // template register layout
  localparam int TPL_ARR_LSB  = 0;
  localparam int ARR_W        = 2;
  localparam int TPL_SIZE_LSB = 8;
  localparam int SIZE_W       = 4;
  localparam int TPL_ATTR_LSB = 16;
  localparam int ATTR_W       = 5;
  localparam int TPL_SRC_LSB  = 24;

  // output register layout
  localparam int REG_W        = 32;
  localparam int OUT_ARR_LSB  = 28;
  localparam int OUT_WAY_LSB  = 16;
  localparam int OUT_NEXT_LSB = 0;
  localparam int VALID_BIT    = 31;
  localparam int SPACE_BIT    = 30;
  localparam int TID_LSB      = 16;
  localparam int SIZE_LSB     = 8;
  localparam int SRCH_SPACE   = 0;
  localparam int BYTES_W      = 10 + (1 << SIZE_W);

  typedef enum logic [1:0] {
    SRC_PID0 = 2'd0,
    SRC_PID1 = 2'd1,
    SRC_PID2 = 2'd2,
    SRC_NONE = 2'd3
  } tid_src_e;
endpackage

// File: rtl/missfill_tid_mux.sv
module missfill_tid_mux
  import missfill_pkg::*;
#(
  parameter int PID_W = 14
) (
  input  tid_src_e         src_i,
  input  logic             ext_en_i,
  input  logic [PID_W-1:0] ext_pid_i,
  input  logic [PID_W-1:0] pid0_i,
  input  logic [PID_W-1:0] pid1_i,
  input  logic [PID_W-1:0] pid2_i,
  output logic [PID_W-1:0] tid_o,
  output logic [PID_W-1:0] search_o
);
  logic [PID_W-1:0] policy_tid;

  always_comb begin
    case (src_i)
      SRC_PID0: policy_tid = pid0_i;
      SRC_PID1: policy_tid = pid1_i;
      SRC_PID2: policy_tid = pid2_i;
      default:  policy_tid = '0;
    endcase
  end

  assign tid_o    = ext_en_i ? ext_pid_i : policy_tid;
  assign search_o = ext_en_i ? ext_pid_i : pid0_i;
endmodule

// File: rtl/missfill_victim.sv
module missfill_victim #(
  parameter int WAYS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  output logic [WAY_W-1:0] cur_o,
  output logic [WAY_W-1:0] nxt_o
);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  generate
    if (WAYS > 1) begin : g_multi
      logic [WAY_W-1:0] ptr_q;
      always_ff @(posedge clk) begin
        if (rst)        ptr_q <= '0;
        else if (adv_i) ptr_q <= nxt_o;
      end
      assign cur_o = ptr_q;
      // power-of-two way count: natural wrap of the counter is the modulo
      assign nxt_o = ptr_q + WAY_W'(1);
    end else begin : g_single
      logic unused_adv;
      assign unused_adv = adv_i ^ clk ^ rst;
      assign cur_o = '0;
      assign nxt_o = '0;
    end
  endgenerate
endmodule

// File: rtl/missfill_size_dec.sv
module missfill_size_dec
  import missfill_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SIZE_W-1:0] code_i,
  output logic [BYTES_W-1:0] bytes_o
);
  localparam logic [BYTES_W-1:0] ONE = BYTES_W'(1);

  always_ff @(posedge clk) begin
    if (rst) bytes_o <= '0;
    else     bytes_o <= ONE << (32'(code_i) + 32'd10);
  end
endmodule

// File: rtl/tlb_miss_prefill.sv
module tlb_miss_prefill
  import missfill_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PID_W    = 14,
  parameter int WAYS     = 4,
  parameter int PAGE_LSB = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               miss_i,
  input  logic               fetch_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               inst_space_i,
  input  logic               data_space_i,
  input  logic               ext_en_i,
  input  logic [PID_W-1:0]   ext_pid_i,
  input  logic               ext_space_i,
  input  logic [PID_W-1:0]   pid0_i,
  input  logic [PID_W-1:0]   pid1_i,
  input  logic [PID_W-1:0]   pid2_i,
  input  logic [REG_W-1:0]   tmpl_i,
  input  logic [SIZE_W-1:0]  size_code_i,
  output logic [REG_W-1:0]   sel_o,
  output logic [REG_W-1:0]   tag_o,
  output logic [ADDR_W-1:0]  epn_o,
  output logic [REG_W-1:0]   perm_o,
  output logic [REG_W-1:0]   srch_o,
  output logic [REG_W-1:0]   hi_o,
  output logic [BYTES_W-1:0] page_bytes_o
);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  tid_src_e         tid_src;
  logic [PID_W-1:0] miss_tid;
  logic [PID_W-1:0] search_pid;
  logic [WAY_W-1:0] way_cur;
  logic [WAY_W-1:0] way_nxt;
  logic             eff_space;

  logic [REG_W-1:0]  sel_d;
  logic [REG_W-1:0]  tag_d;
  logic [ADDR_W-1:0] epn_d;
  logic [REG_W-1:0]  srch_d;

  logic unused_bits;
  assign unused_bits = ^{tmpl_i[31:26], tmpl_i[23:21], tmpl_i[15:12],
                         tmpl_i[7:2], addr_i[PAGE_LSB-1:0]};

  assign tid_src = tid_src_e'(tmpl_i[TPL_SRC_LSB +: 2]);

  // fetches always take the instruction space; override brings its own space
  assign eff_space = fetch_i ? inst_space_i
                             : (ext_en_i ? ext_space_i : data_space_i);

  missfill_tid_mux #(.PID_W(PID_W)) u_tid (
    .src_i     (tid_src),
    .ext_en_i  (ext_en_i),
    .ext_pid_i (ext_pid_i),
    .pid0_i    (pid0_i),
    .pid1_i    (pid1_i),
    .pid2_i    (pid2_i),
    .tid_o     (miss_tid),
    .search_o  (search_pid)
  );

  missfill_victim #(.WAYS(WAYS)) u_vic (
    .clk   (clk),
    .rst   (rst),
    .adv_i (miss_i),
    .cur_o (way_cur),
    .nxt_o (way_nxt)
  );

  missfill_size_dec u_size (
    .clk     (clk),
    .rst     (rst),
    .code_i  (size_code_i),
    .bytes_o (page_bytes_o)
  );

  always_comb begin
    sel_d = '0;
    sel_d[OUT_ARR_LSB  +: ARR_W] = tmpl_i[TPL_ARR_LSB +: ARR_W];
    sel_d[OUT_WAY_LSB  +: WAY_W] = way_cur;
    sel_d[OUT_NEXT_LSB +: WAY_W] = way_nxt;

    tag_d = '0;
    tag_d[VALID_BIT]              = 1'b1;
    tag_d[SPACE_BIT]              = eff_space;
    tag_d[TID_LSB  +: PID_W]      = miss_tid;
    tag_d[SIZE_LSB +: SIZE_W]     = tmpl_i[TPL_SIZE_LSB +: SIZE_W];

    epn_d = '0;
    epn_d[ADDR_W-1:PAGE_LSB]      = addr_i[ADDR_W-1:PAGE_LSB];
    epn_d[ATTR_W-1:0]             = tmpl_i[TPL_ATTR_LSB +: ATTR_W];

    srch_d = '0;
    srch_d[TID_LSB +: PID_W]      = search_pid;
    srch_d[SRCH_SPACE]            = eff_space;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o  <= '0;
      tag_o  <= '0;
      epn_o  <= '0;
      perm_o <= '0;
      srch_o <= '0;
      hi_o   <= '0;
    end else if (miss_i) begin
      sel_o  <= sel_d;
      tag_o  <= tag_d;
      epn_o  <= epn_d;
      perm_o <= '0;
      srch_o <= srch_d;
      hi_o   <= '0;
    end
  end
endmodule

// File: rtl/missfill_chk.sv
module missfill_chk
  import missfill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PID_W  = 14,
  parameter int WAYS   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               miss_i,
  input logic               fetch_i,
  input logic               inst_space_i,
  input logic               ext_en_i,
  input logic [PID_W-1:0]   ext_pid_i,
  input logic [PID_W-1:0]   pid0_i,
  input logic [SIZE_W-1:0]  size_code_i,
  input logic [REG_W-1:0]   sel_o,
  input logic [REG_W-1:0]   tag_o,
  input logic [ADDR_W-1:0]  epn_o,
  input logic [REG_W-1:0]   srch_o,
  input logic [BYTES_W-1:0] page_bytes_o
);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [WAY_W-1:0] WMASK = WAY_W'(WAYS - 1);
  localparam logic [BYTES_W-1:0] ONE = BYTES_W'(1);

  a_r3_valid_set: assert property (@(posedge clk) disable iff (rst)
    miss_i |=> tag_o[VALID_BIT]);

  a_r4_fetch_space: assert property (@(posedge clk) disable iff (rst)
    miss_i && fetch_i |=> tag_o[SPACE_BIT] == $past(inst_space_i)
                          && srch_o[SRCH_SPACE] == $past(inst_space_i));

  a_r5_search_pid0: assert property (@(posedge clk) disable iff (rst)
    miss_i && !ext_en_i |=> srch_o[TID_LSB +: PID_W] == $past(pid0_i));

  a_r6_ext_ids: assert property (@(posedge clk) disable iff (rst)
    miss_i && ext_en_i |=> tag_o[TID_LSB +: PID_W] == $past(ext_pid_i)
                           && srch_o[TID_LSB +: PID_W] == $past(ext_pid_i));

  a_r7_way_chain: assert property (@(posedge clk) disable iff (rst)
    miss_i |=> sel_o[OUT_WAY_LSB +: WAY_W] == $past(sel_o[OUT_NEXT_LSB +: WAY_W]));

  a_r7_next_way: assert property (@(posedge clk) disable iff (rst)
    miss_i |=> sel_o[OUT_NEXT_LSB +: WAY_W]
               == ((sel_o[OUT_WAY_LSB +: WAY_W] + WAY_W'(1)) & WMASK));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !miss_i |=> $stable(sel_o) && $stable(tag_o) && $stable(epn_o) && $stable(srch_o));

  a_r9_page_bytes: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> page_bytes_o == (ONE << (32'($past(size_code_i)) + 32'd10))
             && $onehot0(page_bytes_o));
endmodule

bind tlb_miss_prefill missfill_chk #(
  .ADDR_W (ADDR_W),
  .PID_W  (PID_W),
  .WAYS   (WAYS)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .miss_i       (miss_i),
  .fetch_i      (fetch_i),
  .inst_space_i (inst_space_i),
  .ext_en_i     (ext_en_i),
  .ext_pid_i    (ext_pid_i),
  .pid0_i       (pid0_i),
  .size_code_i  (size_code_i),
  .sel_o        (sel_o),
  .tag_o        (tag_o),
  .epn_o        (epn_o),
  .srch_o       (srch_o),
  .page_bytes_o (page_bytes_o)
);

// File: tb/tlb_miss_prefill_tb.sv
module tlb_miss_prefill_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        miss_i = 1'b0, fetch_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        inst_space_i = 1'b0, data_space_i = 1'b0;
  logic        ext_en_i = 1'b0, ext_space_i = 1'b0;
  logic [13:0] ext_pid_i = '0, pid0_i = '0, pid1_i = '0, pid2_i = '0;
  logic [31:0] tmpl_i = '0;
  logic [3:0]  size_code_i = '0;
  logic [31:0] sel_o, tag_o, epn_o, perm_o, srch_o, hi_o;
  logic [25:0] page_bytes_o;

  int n_chk = 0, n_bad = 0;
  int vic = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tlb_miss_prefill u_dut (
    .clk(clk), .rst(rst), .miss_i(miss_i), .fetch_i(fetch_i), .addr_i(addr_i),
    .inst_space_i(inst_space_i), .data_space_i(data_space_i),
    .ext_en_i(ext_en_i), .ext_pid_i(ext_pid_i), .ext_space_i(ext_space_i),
    .pid0_i(pid0_i), .pid1_i(pid1_i), .pid2_i(pid2_i), .tmpl_i(tmpl_i),
    .size_code_i(size_code_i), .sel_o(sel_o), .tag_o(tag_o), .epn_o(epn_o),
    .perm_o(perm_o), .srch_o(srch_o), .hi_o(hi_o), .page_bytes_o(page_bytes_o)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // one miss; expected register values computed from the requirements
  task automatic do_miss(input string req, input logic [31:0] a, input logic f,
                         input logic is, input logic ds, input logic xe,
                         input logic [13:0] xp, input logic xs, input logic [31:0] t);
    logic sp;
    logic [13:0] tid, spid;
    @(negedge clk);
    addr_i = a; fetch_i = f; inst_space_i = is; data_space_i = ds;
    ext_en_i = xe; ext_pid_i = xp; ext_space_i = xs; tmpl_i = t; miss_i = 1'b1;
    @(negedge clk);
    miss_i = 1'b0;
    sp = f ? is : (xe ? xs : ds);
    if (xe) begin tid = xp; spid = xp; end
    else begin
      spid = pid0_i;
      case (t[25:24])
        2'd0: tid = pid0_i;
        2'd1: tid = pid1_i;
        2'd2: tid = pid2_i;
        default: tid = '0;
      endcase
    end
    chk({req, " sel"},  sel_o, {32'd0, 2'b00, t[1:0], 10'd0, 2'(vic), 14'd0, 2'((vic + 1) % 4)});
    chk({req, " tag"},  tag_o, {32'd0, 1'b1, sp, tid, 4'd0, t[11:8], 8'd0});
    chk({req, " epn"},  epn_o, {32'd0, a[31:12], 7'd0, t[20:16]});
    chk({req, " srch"}, srch_o, {32'd0, 2'b00, spid, 15'd0, sp});
    chk({req, " perm/hi"}, {perm_o, hi_o}, 64'd0);
    vic = (vic + 1) % 4;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 sel", sel_o, 0);
    chk("R1 tag", tag_o, 0);
    chk("R1 epn/srch", {epn_o, srch_o}, 0);
    chk("R1 perm/hi", {perm_o, hi_o}, 0);
    chk("R1 page", page_bytes_o, 0);
    rst = 1'b0;
    vic = 0;
  endtask

  task automatic t_defaults;
    // R2 R3: template fields, valid bit, page number
    do_miss("R2/R3 dflt-a", 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0, 32'h0015_0A03);
    do_miss("R2/R3 dflt-b", 32'h0000_1FFF, 0, 0, 0, 0, 0, 0, 32'h001A_0501);
  endtask

  task automatic t_space;
    do_miss("R4 fetch-inst1", 32'h1234_5678, 1, 1, 0, 0, 0, 0, 32'h0);
    do_miss("R4 fetch-over-ext", 32'h1234_5678, 1, 0, 1, 1, 14'h0111, 1, 32'h0);
    do_miss("R4 data1", 32'h8000_0000, 0, 0, 1, 0, 0, 0, 32'h0);
    do_miss("R4 ext-space", 32'h8000_0000, 0, 0, 0, 1, 14'h0222, 1, 32'h0);
  endtask

  task automatic t_tid_src;
    pid0_i = 14'h0123; pid1_i = 14'h2A5C; pid2_i = 14'h3FFF;
    do_miss("R5 sel0", 32'hA000_0000, 0, 0, 0, 0, 0, 0, 32'h0000_0000);
    do_miss("R5 sel1", 32'hA000_1000, 0, 0, 0, 0, 0, 0, 32'h0100_0000);
    do_miss("R5 sel2", 32'hA000_2000, 0, 0, 0, 0, 0, 0, 32'h0200_0000);
    do_miss("R5 sel3", 32'hA000_3000, 0, 0, 0, 0, 0, 0, 32'h0300_0000);
  endtask

  task automatic t_ext;
    do_miss("R6 ext sel1", 32'hB000_0000, 0, 0, 0, 1, 14'h1B0D, 0, 32'h0100_0000);
    do_miss("R6 ext sel3", 32'hB000_0000, 0, 0, 0, 1, 14'h0001, 0, 32'h0300_0000);
  endtask

  task automatic t_victim;
    // R7: wrap 3 -> 0 covered by consecutive misses
    for (int i = 0; i < 5; i++)
      do_miss("R7 wrap", 32'hC000_0000 + (i << 12), 0, 0, 0, 0, 0, 0, 32'h3);
  endtask

  task automatic t_hold;
    logic [31:0] s, tg, e, sr;
    s = sel_o; tg = tag_o; e = epn_o; sr = srch_o;
    @(negedge clk);
    addr_i = 32'hFFFF_FFFF; tmpl_i = 32'hFFFF_FFFF; pid0_i = 14'h0AAA;
    ext_en_i = 1; ext_pid_i = 14'h3333; inst_space_i = 1; data_space_i = 1;
    repeat (3) @(negedge clk);
    chk("R8 sel hold", sel_o, s);
    chk("R8 tag hold", tag_o, tg);
    chk("R8 epn/srch hold", {epn_o, sr == srch_o}, {e, 1'b1});
    // pointer must not have moved: next miss reports the expected way
    do_miss("R8 no-advance", 32'h0, 0, 0, 0, 0, 0, 0, 32'h0);
  endtask

  task automatic t_pagesize;
    int codes[3] = '{0, 5, 15};
    foreach (codes[k]) begin
      @(negedge clk);
      size_code_i = 4'(codes[k]);
      @(negedge clk);
      chk("R9 page bytes", page_bytes_o, 64'd1024 << codes[k]);
    end
  endtask

  initial begin
    t_reset();
    t_defaults();
    t_space();
    t_tid_src();
    t_ext();
    t_victim();
    t_hold();
    t_pagesize();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule